// File: doc/BRIEF.md
# PCI Function Configuration Header

This block holds the configuration space of a single-function PCI target. It covers the predefined header region and two base address registers: one maps the function into memory space and one maps it into I/O space. The bus protocol engine sits outside the block. That engine drives a plain register port whenever an IDSEL-qualified configuration cycle targets the function. The port carries a select, a write strobe, a 6-bit dword index covering all 256 bytes, byte enables and write data. The block returns read data on the same port.

The host sizes each window the usual way. It writes all ones to a base register and reads the value back. Bits below the implemented window size are hardwired to zero, so the value read back is the size mask together with the fixed type bits. The host then writes the chosen base. The block compares each incoming bus address against the programmed bases. It raises a hit per window when the matching decode enable in the command register is set.

Top module: `pcicfg_hdr`

## Requirements
- R1: After reset the command register and both base fields are zero. Dword 1 reads 0, dword 4 reads 0 and dword 5 reads 32'h00000001.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 2 reads {CLASS_CODE, REVISION}. Dword 3 reads HEADER_TYPE in bits 23:16 and zero elsewhere. Writes to these dwords leave them unchanged.
- R3: While cfg_sel is low, cfg_rdata is zero and cfg_we has no effect on any register.
- R4: The memory window register is dword 4. Bit 0 reads 0 (memory space), bits 2:1 read 00 (32-bit decoder) and bit 3 reads 0 (not prefetchable). Bits below MEM_WIN_LOG2 (at least 4) read zero. Writing all ones reads back ~(2**MEM_WIN_LOG2-1).
- R5: The I/O window register is dword 5. Bit 0 reads 1 and bit 1 reads 0. Bits below IO_WIN_LOG2 (2 to 8) read zero. Writing all ones reads back ~(2**IO_WIN_LOG2-1) | 1.
- R6: On a selected write, byte k of cfg_wdata reaches a register only when cfg_be[k] is 1. Bytes whose enable is 0 keep their value.
- R7: Dword 1 holds the command register. Bit 0 is the I/O decode enable and bit 1 is the memory decode enable, and both are writable. All other bits of the dword read 0.
- R8: mem_hit is 1 exactly when command bit 1 is set and bus_addr[31:MEM_WIN_LOG2] equals the programmed memory base. It is combinational from bus_addr.
- R9: io_hit is 1 exactly when command bit 0 is set and bus_addr[31:IO_WIN_LOG2] equals the programmed I/O base. It is combinational from bus_addr.
- R10: Dword indices 6 to 63 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sel | input | 1 | Configuration access to this function (IDSEL qualified) |
| cfg_we | input | 1 | Write strobe, 1 = write, 0 = read |
| cfg_idx | input | 6 | Dword index into the 256-byte space |
| cfg_be | input | 4 | Byte enables, bit k covers cfg_wdata[8k+7:8k] |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| bus_addr | input | 32 | Address of the current bus transaction |
| mem_hit | output | 1 | Address falls in the memory window |
| io_hit | output | 1 | Address falls in the I/O window |

## Verification
The bench builds the block with a 4 KB memory window (MEM_WIN_LOG2 = 12) and a 32-location I/O window (IO_WIN_LOG2 = 5). With these sizes, some written bits lie below each window and must be dropped, while others are kept. A byte lane can also straddle the window edge, which makes a partial write visible in the read-back value. Both windows are placed at bases whose neighbours differ by one address, so the hit checks probe the first and last address inside each window and the first address outside it. They also probe the effect of each decode enable.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  localparam int unsigned IDX_W = 6;

  // dword slots; the host decodes these positions, so they are fixed
  localparam logic [IDX_W-1:0] SLOT_IDENT = 6'd0;
  localparam logic [IDX_W-1:0] SLOT_CMD   = 6'd1;
  localparam logic [IDX_W-1:0] SLOT_CLASS = 6'd2;
  localparam logic [IDX_W-1:0] SLOT_HTYPE = 6'd3;
  localparam logic [IDX_W-1:0] SLOT_MWIN  = 6'd4;
  localparam logic [IDX_W-1:0] SLOT_IOWIN = 6'd5;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/pcicfg_rst_sync.sv
module pcicfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/pcicfg_cmd.sv
module pcicfg_cmd (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       lane0_en,
  input  logic [1:0] wbits,
  output logic       io_en,
  output logic       mem_en
);

  logic [1:0] cmd_q, cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (wr_en && lane0_en) cmd_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= 2'b00;
    else        cmd_q <= cmd_d;
  end

  assign io_en  = cmd_q[0];
  assign mem_en = cmd_q[1];

  // R7: enables move only on a write that carries lane 0
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && lane0_en) |=> $stable(cmd_q));

  a_r7_cmd_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lane0_en) |=> cmd_q == $past(wbits));

endmodule

// File: rtl/pcicfg_bar.sv
module pcicfg_bar #(
  parameter int unsigned WIN_LOG2 = 12,
  parameter bit          IS_IO    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        dec_en,
  input  logic [31:0] addr,
  output logic [31:0] rd_val,
  output logic        hit
);

  import pcicfg_pkg::*;

  localparam logic [31:0] WIN_MASK = ~((32'd1 << WIN_LOG2) - 32'd1);

  logic [31:0] type_bits;
  logic [31:0] base_q, base_d;
  logic [31:0] lanes;

  generate
    if (IS_IO) begin : g_io
      assign type_bits = 32'h0000_0001;   // I/O space, bit 1 reserved
    end else begin : g_mem
      assign type_bits = 32'h0000_0000;   // memory, 32-bit, not prefetchable
    end
  endgenerate

  always_comb begin
    lanes  = lane_mask(be);
    base_d = base_q;
    if (wr_en) base_d = ((base_q & ~lanes) | (wdata & lanes)) & WIN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= 32'd0;
    else        base_q <= base_d;
  end

  assign rd_val = base_q | type_bits;
  assign hit    = dec_en && ((addr & WIN_MASK) == base_q);

  // R6: the base is untouched without a selected write
  a_r6_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q));

  // R6: a write with every lane enabled keeps exactly the window-aligned bits
  a_r6_full_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be == 4'hF) |=> base_q == ($past(wdata) & WIN_MASK));

endmodule

// File: rtl/pcicfg_hdr.sv
module pcicfg_hdr #(
  parameter logic [15:0] VENDOR_ID    = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID    = 16'hA51C,
  parameter logic [23:0] CLASS_CODE   = 24'h118000,
  parameter logic [7:0]  REVISION     = 8'h02,
  parameter logic [7:0]  HEADER_TYPE  = 8'h00,
  parameter int unsigned MEM_WIN_LOG2 = 12,
  parameter int unsigned IO_WIN_LOG2  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_sel,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_idx,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] bus_addr,
  output logic        mem_hit,
  output logic        io_hit
);

  import pcicfg_pkg::*;

  logic        rst_s_n;
  logic        wr_any;
  logic        io_en, mem_en;
  logic [31:0] mwin_val, iowin_val;

  pcicfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign wr_any = cfg_sel && cfg_we;

  pcicfg_cmd u_cmd (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (wr_any && (cfg_idx == SLOT_CMD)),
    .lane0_en (cfg_be[0]),
    .wbits    (cfg_wdata[1:0]),
    .io_en    (io_en),
    .mem_en   (mem_en)
  );

  pcicfg_bar #(.WIN_LOG2(MEM_WIN_LOG2), .IS_IO(1'b0)) u_mwin (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (wr_any && (cfg_idx == SLOT_MWIN)),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .dec_en (mem_en),
    .addr   (bus_addr),
    .rd_val (mwin_val),
    .hit    (mem_hit)
  );

  pcicfg_bar #(.WIN_LOG2(IO_WIN_LOG2), .IS_IO(1'b1)) u_iowin (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (wr_any && (cfg_idx == SLOT_IOWIN)),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .dec_en (io_en),
    .addr   (bus_addr),
    .rd_val (iowin_val),
    .hit    (io_hit)
  );

  always_comb begin
    cfg_rdata = 32'd0;
    if (cfg_sel) begin
      unique case (cfg_idx)
        SLOT_IDENT: cfg_rdata = {DEVICE_ID, VENDOR_ID};
        SLOT_CMD:   cfg_rdata = {30'd0, mem_en, io_en};
        SLOT_CLASS: cfg_rdata = {CLASS_CODE, REVISION};
        SLOT_HTYPE: cfg_rdata = {8'h00, HEADER_TYPE, 16'h0000};
        SLOT_MWIN:  cfg_rdata = mwin_val;
        SLOT_IOWIN: cfg_rdata = iowin_val;
        default:    cfg_rdata = 32'd0;
      endcase
    end
  end

  // R3: nothing is driven back while the function is not addressed
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cfg_sel |-> cfg_rdata == 32'd0);

  // R4: fixed type nibble of the memory window
  a_r4_mem_type: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_sel && cfg_idx == SLOT_MWIN) |-> cfg_rdata[3:0] == 4'b0000);

  // R5: fixed type bits of the I/O window
  a_r5_io_type: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_sel && cfg_idx == SLOT_IOWIN) |-> cfg_rdata[1:0] == 2'b01);

  // R10: unimplemented dwords read as zero
  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_sel && cfg_idx > SLOT_IOWIN) |-> cfg_rdata == 32'd0);

  // R8/R9: a hit never appears while its decode enable is clear
  a_r8_mem_gate: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_hit |-> mem_en);
  a_r9_io_gate: assert property (@(posedge clk) disable iff (!rst_s_n)
    io_hit |-> io_en);

endmodule

// File: tb/sim_pcicfg_hdr.sv
module sim_pcicfg_hdr;

  localparam logic [15:0] VEN  = 16'h1D0F;
  localparam logic [15:0] DEV  = 16'hA51C;
  localparam logic [23:0] CLS  = 24'h118000;
  localparam logic [7:0]  REV  = 8'h02;
  localparam logic [7:0]  HDR  = 8'h00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_sel, cfg_we;
  logic [5:0]  cfg_idx;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata, bus_addr;
  logic        mem_hit, io_hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pcicfg_hdr #(
    .VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_CODE(CLS), .REVISION(REV),
    .HEADER_TYPE(HDR), .MEM_WIN_LOG2(12), .IO_WIN_LOG2(5)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
    .mem_hit(mem_hit), .io_hit(io_hit)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] expect_rd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{6'd4, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_F000},   // R4 sizing
    '{6'd5, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFE1},   // R5 sizing
    '{6'd4, 4'hF, 32'h1234_5678, 32'h1234_5000},   // R4 low bits dropped
    '{6'd4, 4'h2, 32'h0000_AB00, 32'h1234_A000},   // R6 lane 1 straddles edge
    '{6'd4, 4'h8, 32'h9A00_0000, 32'h9A34_A000},   // R6 lane 3 only
    '{6'd5, 4'hF, 32'h0000_C3A7, 32'h0000_C3A1},   // R5 base program
    '{6'd1, 4'hF, 32'hFFFF_FFFF, 32'h0000_0003},   // R7 two bits only
    '{6'd1, 4'hE, 32'h0000_0000, 32'h0000_0003},   // R6 lane 0 off
    '{6'd0, 4'hF, 32'h0000_0000, {DEV, VEN}},      // R2 ident
    '{6'd2, 4'hF, 32'h0000_0000, {CLS, REV}},      // R2 class
    '{6'd3, 4'hF, 32'hFFFF_FFFF, {8'h00, HDR, 16'h0}}, // R2 header type
    '{6'd9, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},   // R10 unimplemented
    '{6'd1, 4'hF, 32'h0000_0002, 32'h0000_0002}    // R7 memory enable only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_we = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] idx, output logic [31:0] v);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_we = 1'b0; cfg_idx = idx;
    #1 v = cfg_rdata;
  endtask

  task automatic probe(input logic [31:0] a, output logic m, output logic i);
    @(negedge clk);
    bus_addr = a;
    #1; m = mem_hit; i = io_hit;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic m, i;
    cfg_sel = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_be = '0;
    cfg_wdata = '0; bus_addr = '0;
    do_reset();

    // R1 reset state
    rd(6'd1, v); check("R1 cmd", v, 32'h0);
    rd(6'd4, v); check("R1 mem window", v, 32'h0);
    rd(6'd5, v); check("R1 io window", v, 32'h1);

    for (int k = 0; k < NV; k++) begin
      wr(VECS[k].idx, VECS[k].be, VECS[k].wdata);
      rd(VECS[k].idx, v);
      check($sformatf("R2/R4/R5/R6/R7/R10 vector %0d", k), v, VECS[k].expect_rd);
    end

    // memory decode on (cmd=2), base 9A34A000 / 4 KB; I/O base C3A0 / 32
    probe(32'h9A34_A000, m, i); check("R8 first in mem", {31'd0, m}, 32'd1);
    probe(32'h9A34_AFFF, m, i); check("R8 last in mem", {31'd0, m}, 32'd1);
    probe(32'h9A34_B000, m, i); check("R8 past mem", {31'd0, m}, 32'd0);
    probe(32'h0000_C3A4, m, i); check("R9 io disabled", {31'd0, i}, 32'd0);

    wr(6'd1, 4'h1, 32'h0000_0001);
    probe(32'h9A34_A010, m, i); check("R8 mem disabled", {31'd0, m}, 32'd0);
    probe(32'h0000_C3A0, m, i); check("R9 first in io", {31'd0, i}, 32'd1);
    probe(32'h0000_C3BF, m, i); check("R9 last in io", {31'd0, i}, 32'd1);
    probe(32'h0000_C3C0, m, i); check("R9 past io", {31'd0, i}, 32'd0);
    probe(32'h0000_C39F, m, i); check("R9 below io", {31'd0, i}, 32'd0);

    // R3 unselected access
    @(negedge clk);
    cfg_sel = 1'b0; cfg_we = 1'b0; cfg_idx = 6'd0;
    #1 check("R3 idle read", cfg_rdata, 32'h0);
    @(negedge clk);
    cfg_sel = 1'b0; cfg_we = 1'b1; cfg_idx = 6'd4; cfg_be = 4'hF; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    rd(6'd4, v); check("R3 write ignored", v, 32'h9A34_A000);

    // R1 reset mid-run
    @(negedge clk); cfg_sel = 1'b0;
    do_reset();
    rd(6'd1, v); check("R1 cmd after reset", v, 32'h0);
    rd(6'd4, v); check("R1 mem after reset", v, 32'h0);
    rd(6'd5, v); check("R1 io after reset", v, 32'h1);
    probe(32'h0000_0000, m, i); check("R1 no hit after reset", {30'd0, m, i}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule